// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is a chain of boundary scan cells that sits between a chip's pads and its core logic. It has one cell for each input pad and one for each output pad. Each cell has a capture stage and an update latch. All capture stages are linked in series from a scan input to a scan output. An external test controller drives three strobes that are sampled on the single test clock. The capture strobe is a synchronous enable, and a shift select decides whether it loads parallel data or serial data. The update strobe copies the capture stages into the update latches.

A two-bit mode input selects one of four behaviours:

- **Transparent functional operation.** Pads pass straight to the core and back.
- **Sampling during normal operation.** Traffic passes unchanged, and the capture strobe records the live pad and core values.
- **Interconnect test.** The output pads are driven from the update latches.
- **Internal test.** The core inputs are driven from the update latches, which isolates the core from the pins.

A small decoder turns the registered mode into one select for the input cells and one for the output cells.

Top module: `bscan_chain`

## Requirements
- R1: While rst_ni is low, all capture stages and update latches clear and the registered mode returns to functional. The first cycle after reset is therefore pass-through.
- R2: mode_i is encoded as 0 functional, 1 sample, 2 interconnect test, 3 internal test. It is registered, so a new value takes effect on the outputs one clock edge after it is applied.
- R3: In functional and sample modes, core_in_o equals pad_in_i and pad_out_o equals core_out_i, combinationally, whatever the chain is doing.
- R4: In interconnect test mode, pad_out_o bit j shows the update latch of output cell j, and core_in_o still equals pad_in_i.
- R5: In internal test mode, core_in_o bit k shows the update latch of input cell k, and pad_out_o still equals core_out_i.
- R6: On a clock edge with clock_dr_i high and shift_dr_i low, each cell's capture stage loads its parallel input. Chain position k (0 to N_IN-1) is input cell k and loads pad_in_i[k]. Position N_IN+j is output cell j and loads core_out_i[j].
- R7: On a clock edge with clock_dr_i and shift_dr_i both high, position 0 loads sin_i and each position k loads position k-1. sout_o always shows the capture stage of the last position.
- R8: On a clock edge with update_dr_i high, every update latch takes the value its capture stage held before that edge. Without update_dr_i the latches hold, so shifting leaves the driven outputs untouched.
- R9: On a clock edge with clock_dr_i low, every capture stage holds its value, and sout_o stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock for all cell registers |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Test mode (0 func, 1 sample, 2 interconnect, 3 internal) |
| shift_dr_i | input | 1 | Selects serial load (1) or parallel load (0) |
| clock_dr_i | input | 1 | Capture stage load enable |
| update_dr_i | input | 1 | Update latch load enable |
| sin_i | input | 1 | Serial input to chain position 0 |
| sout_o | output | 1 | Serial output from the last chain position |
| pad_in_i | input | N_IN | Values from the input pads |
| core_in_o | output | N_IN | Values delivered to core inputs |
| core_out_i | input | N_OUT | Values from core outputs |
| pad_out_o | output | N_OUT | Values delivered to output pads |

## Verification
The bench targets the following failure points:

- **Cell ordering.** The bench captures distinct input and output patterns, then shifts them out. A chain with swapped halves or a reversed index would produce a different bit sequence on sout_o.
- **Update latch isolation.** The bench shifts new data while interconnect and internal test modes drive from the latches. A design that let the capture stage reach the outputs would show the shifting bits on the pads or the core.
- **Per-cell mode selects.** The bench checks the selects in all four modes. A decoder that swapped the input and output selects would drive the wrong side.
- **Mode latency.** Mode changes fall between strobes, so a decoder that reads mode_i without registering it is off by one cycle.
- **Reset clearing.** The bench enters internal test mode straight after reset. If the latches did not clear, non-zero values would reach the core.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic [1:0] {
    BSC_FUNC   = 2'd0,
    BSC_SAMPLE = 2'd1,
    BSC_EXTEST = 2'd2,
    BSC_INTEST = 2'd3
  } bsc_mode_e;

  typedef struct packed {
    logic core_from_upd;  // input cells drive core from latch
    logic pad_from_upd;   // output cells drive pad from latch
  } bsc_sel_t;
endpackage

// File: rtl/bsc_mode_dec.sv
module bsc_mode_dec
  import bsc_pkg::*;
(
  input  bsc_mode_e mode_i,
  output bsc_sel_t  sel_o
);
  always_comb begin
    sel_o = '0;
    unique case (mode_i)
      BSC_EXTEST: sel_o.pad_from_upd  = 1'b1;
      BSC_INTEST: sel_o.core_from_upd = 1'b1;
      default:    sel_o = '0;
    endcase
  end
endmodule

// File: rtl/bsc_cell.sv
module bsc_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_en_i,
  input  logic shift_i,
  input  logic upd_en_i,
  input  logic scan_i,
  input  logic par_i,
  input  logic drive_upd_i,
  output logic scan_o,
  output logic upd_o,
  output logic func_o
);
  logic cap_q, upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cap_q <= 1'b0;
    else if (cap_en_i) cap_q <= shift_i ? scan_i : par_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       upd_q <= 1'b0;
    else if (upd_en_i) upd_q <= cap_q;
  end

  assign scan_o = cap_q;
  assign upd_o  = upd_q;
  assign func_o = drive_upd_i ? upd_q : par_i;
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bsc_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             shift_dr_i,
  input  logic             clock_dr_i,
  input  logic             update_dr_i,
  input  logic             sin_i,
  output logic             sout_o,
  input  logic [N_IN-1:0]  pad_in_i,
  output logic [N_IN-1:0]  core_in_o,
  input  logic [N_OUT-1:0] core_out_i,
  output logic [N_OUT-1:0] pad_out_o
);
  localparam int N = N_IN + N_OUT;

  bsc_mode_e mode_q;
  bsc_sel_t  sel;
  logic [N-1:0] cap_q, upd_q, par_in, func_out, drive_upd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= BSC_FUNC;
    else         mode_q <= bsc_mode_e'(mode_i);
  end

  bsc_mode_dec u_dec (.mode_i(mode_q), .sel_o(sel));

  assign par_in = {core_out_i, pad_in_i};

  for (genvar k = 0; k < N; k++) begin : g_cell
    if (k < N_IN) begin : g_in
      assign drive_upd[k] = sel.core_from_upd;
    end else begin : g_out
      assign drive_upd[k] = sel.pad_from_upd;
    end

    bsc_cell u_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cap_en_i    (clock_dr_i),
      .shift_i     (shift_dr_i),
      .upd_en_i    (update_dr_i),
      .scan_i      ((k == 0) ? sin_i : cap_q[(k == 0) ? 0 : k-1]),
      .par_i       (par_in[k]),
      .drive_upd_i (drive_upd[k]),
      .scan_o      (cap_q[k]),
      .upd_o       (upd_q[k]),
      .func_o      (func_out[k])
    );
  end

  assign core_in_o = func_out[N_IN-1:0];
  assign pad_out_o = func_out[N-1:N_IN];
  assign sout_o    = cap_q[N-1];
endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk
  import bsc_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             shift_dr_i,
  input logic             clock_dr_i,
  input logic             update_dr_i,
  input logic             sin_i,
  input logic             sout_o,
  input logic [N_IN-1:0]  pad_in_i,
  input logic [N_IN-1:0]  core_in_o,
  input logic [N_OUT-1:0] core_out_i,
  input logic [N_OUT-1:0] pad_out_o,
  input bsc_mode_e        mode_q,
  input logic [N_IN+N_OUT-1:0] cap_q,
  input logic [N_IN+N_OUT-1:0] upd_q
);
  localparam int N = N_IN + N_OUT;

  p_mode_reg_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> mode_q == bsc_mode_e'($past(mode_i)));

  p_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == BSC_FUNC || mode_q == BSC_SAMPLE) |->
      (core_in_o == pad_in_i && pad_out_o == core_out_i));

  p_extest_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == BSC_EXTEST |->
      (pad_out_o == upd_q[N-1:N_IN] && core_in_o == pad_in_i));

  p_intest_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == BSC_INTEST |->
      (core_in_o == upd_q[N_IN-1:0] && pad_out_o == core_out_i));

  p_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clock_dr_i && !shift_dr_i) |=> cap_q == $past({core_out_i, pad_in_i}));

  p_shift_head_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clock_dr_i && shift_dr_i) |=> cap_q[0] == $past(sin_i));

  p_shift_tail_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clock_dr_i && shift_dr_i) |=> sout_o == $past(cap_q[N-2]));

  p_update_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_dr_i |=> upd_q == $past(cap_q));

  p_upd_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_dr_i |=> $stable(upd_q));

  p_cap_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clock_dr_i |=> ($stable(cap_q) && $stable(sout_o)));
endmodule

bind bscan_chain bscan_chain_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .shift_dr_i  (shift_dr_i),
  .clock_dr_i  (clock_dr_i),
  .update_dr_i (update_dr_i),
  .sin_i       (sin_i),
  .sout_o      (sout_o),
  .pad_in_i    (pad_in_i),
  .core_in_o   (core_in_o),
  .core_out_i  (core_out_i),
  .pad_out_o   (pad_out_o),
  .mode_q      (mode_q),
  .cap_q       (cap_q),
  .upd_q       (upd_q)
);

// File: tb/bscan_chain_bench.sv
module bscan_chain_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN  = 4;
  localparam int N_OUT = 4;
  localparam int N = N_IN + N_OUT;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] mode = 2'd0;
  logic shift_dr = 1'b0, clock_dr = 1'b0, update_dr = 1'b0, sin = 1'b0;
  logic sout;
  logic [N_IN-1:0]  pad_in = '0, core_in;
  logic [N_OUT-1:0] core_out = '0, pad_out;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  logic cap_m[$];
  logic [N-1:0] upd_m = '0;
  int mode_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bscan_chain #(.N_IN(N_IN), .N_OUT(N_OUT)) u_bscan_chain (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .shift_dr_i(shift_dr),
    .clock_dr_i(clock_dr), .update_dr_i(update_dr), .sin_i(sin), .sout_o(sout),
    .pad_in_i(pad_in), .core_in_o(core_in), .core_out_i(core_out), .pad_out_o(pad_out)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic [N_IN-1:0]  exp_core;
    logic [N_OUT-1:0] exp_pad;
    string mt;
    for (int k = 0; k < N_IN; k++)
      exp_core[k] = (mode_m == 3) ? upd_m[k] : pad_in[k];
    for (int j = 0; j < N_OUT; j++)
      exp_pad[j] = (mode_m == 2) ? upd_m[N_IN+j] : core_out[j];
    mt = (mode_m == 3) ? "R5" : (mode_m == 2) ? "R4" : "R3";
    check(32'(core_in), 32'(exp_core), {mt, " core_in ", tag});
    check(32'(pad_out), 32'(exp_pad), {mt, " pad_out ", tag});
    check(32'(sout), 32'(cap_m[N-1]), {"R7 sout ", tag});
  endtask

  task automatic step(input int md, input logic sh, input logic ck, input logic up,
                      input logic si, input string tag);
    logic [31:0] r1, r2;
    r1 = $urandom; r2 = $urandom;
    mode = 2'(md); shift_dr = sh; clock_dr = ck; update_dr = up; sin = si;
    pad_in = r1[N_IN-1:0]; core_out = r2[N_OUT-1:0];
    #1;
    compare(tag);
    @(posedge clk);
    if (up) for (int k = 0; k < N; k++) upd_m[k] = cap_m[k];
    if (ck) begin
      if (sh) begin
        cap_m.push_front(si);
        void'(cap_m.pop_back());
      end else begin
        for (int k = 0; k < N; k++)
          cap_m[k] = (k < N_IN) ? pad_in[k] : core_out[k-N_IN];
      end
    end
    mode_m = md;
    @(negedge clk);
  endtask

  initial begin
    logic [N-1:0] pat;
    for (int k = 0; k < N; k++) cap_m.push_back(1'b0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: internal test right after reset must show cleared latches
    step(3, 0, 0, 0, 0, "R1 post-reset");
    step(3, 0, 0, 0, 0, "R1 cleared latches");
    step(0, 0, 0, 0, 0, "R2 back to func");
    // R6: sample mode capture, then shift out
    step(1, 0, 1, 0, 0, "R6 capture");
    for (int i = 0; i < N; i++) step(1, 1, 1, 0, i[0], "R7 shift out");
    // R8: shift a pattern, then update
    pat = 8'hA6;
    for (int i = 0; i < N; i++) step(0, 1, 1, 0, pat[N-1-i], "R7 shift in");
    step(0, 0, 0, 1, 0, "R8 update");
    step(2, 0, 0, 0, 0, "R4 extest");
    step(2, 0, 0, 0, 0, "R4 extest hold");
    // shift without update: driven pads must not move
    for (int i = 0; i < N; i++) step(2, 1, 1, 0, ~i[0], "R8 shift no update");
    step(2, 0, 0, 1, 0, "R8 update in extest");
    step(3, 0, 0, 0, 0, "R5 intest");
    for (int i = 0; i < N; i++) step(3, 1, 1, 0, i[1], "R8 intest shift");
    step(3, 0, 1, 1, 0, "R8 capture with update");
    step(3, 0, 0, 0, 0, "R5 intest after");
    // R9: no capture enable, chain holds
    for (int i = 0; i < 6; i++) step(i % 4, 1, 0, 0, 1, "R9 hold");
    // R2: mode changes every cycle
    for (int i = 0; i < 12; i++) step((i * 3) % 4, i[0], i[1], i[2], i[0], "R2 mode change");
    for (int i = 0; i < 40; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(int'(r[1:0]), r[2], r[3], r[4], r[5], "R6 mixed");
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule